// File: doc/BRIEF.md
# Indirect Peripheral Bus Bridge

This bridge lets a host reach two 8-bit peripheral devices ("guests") through a single 32-bit command/status word. The host writes one word that selects the target guest, whether the cycle carries a register offset or a data byte, the direction, and the byte to send. The bridge then runs one cycle on a shared 8-bit guest bus with a chip select per guest, an address-latch strobe, and separate read and write strobes. While the cycle runs, a busy flag in the same word reads as 1. When a read cycle ends, the byte returned by the guest appears in the low byte of that word.

A complete guest register access takes two commands: first an address-phase command that latches the register offset inside the guest, then a data-phase command that reads or writes the byte at that offset. Software waits for the busy flag to clear before it issues each command. A FIFO inside a guest is drained by repeating the address phase, with the FIFO's fixed offset, before every data byte. Guest 1 holds two channels, and bit 6 of the offset chooses between them. The bridge passes that offset through unchanged.

Top module: `pbus_bridge`

## Requirements
- R1: The command/status word sits at host byte offset 0x200. A host read of that offset returns busy in bit 25, direction in bit 23 (1 = write to guest), guest select in bit 20, phase in bit 16 (0 = address, 1 = data) and the byte field in bits 7:0. All other bits read 0. A host read of any other offset returns 0, and a host write to any other offset has no effect.
- R2: After reset, busy is 0, the word reads 0 (byte field 0x00), both chip selects are high, the address-latch strobe is low, both the read and write strobes are high, and the bridge does not drive the guest bus.
- R3: A host write to the word while busy is 0 is accepted. Busy reads 1 on the clock after acceptance and stays 1 for STROBE_CLKS+2 clocks.
- R4: A host write to the word while busy is 1 is ignored. The word keeps its contents, and no further guest cycle starts.
- R5: An address-phase command (bit 16 = 0) drives bits 7:0 onto the guest bus for its whole cycle. It holds the address-latch strobe high for STROBE_CLKS clocks, beginning one clock after busy rises, whatever the value of bit 23. Neither the read strobe nor the write strobe is asserted.
- R6: A data write (bit 16 = 1, bit 23 = 1) drives bits 7:0 onto the guest bus and holds the write strobe low for STROBE_CLKS clocks, beginning one clock after busy rises.
- R7: A data read (bit 16 = 1, bit 23 = 0) releases the guest bus and holds the read strobe low for STROBE_CLKS clocks. The byte present on the bus in the last clock of that strobe is stored in bits 7:0. Bits 23, 20 and 16 keep the values that were written.
- R8: Bit 20 selects the guest: chip select 0 for guest 0, chip select 1 for guest 1. At most one chip select is low at any time, and every strobe is asserted only while a chip select is low.
- R9: The chip select stays low for one clock after the strobe is released. Busy clears at the end of that clock, and the chip select rises with it.
- R10: Back-to-back command pairs run correctly, each an address phase at a fixed FIFO offset followed by a data read, including the second-channel offset (bit 6 set) on guest 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| gbus_cs_n | output | 2 | Active-low chip select per guest |
| gbus_ale | output | 1 | Address-latch strobe, active high |
| gbus_rd_n | output | 1 | Read strobe, active low |
| gbus_wr_n | output | 1 | Write strobe, active low |
| gbus_ad_o | output | 8 | Address/data byte to the guests |
| gbus_ad_oe | output | 1 | Output enable for gbus_ad_o |
| gbus_ad_i | input | 8 | Byte returned by the guests |

## Verification
The bench builds the bridge with STROBE_CLKS = 2 and the default 12-bit host offset. This gives the shortest strobe that still has a distinct first and last strobe clock, so each cycle checks the strobe start, the strobe end, the sample of the returned byte on the last read clock, and the one-clock chip-select hold. The short cycle also leaves room for a write issued in the middle of a busy cycle, which checks that such a write is ignored. A behavioural model of two guests latches offsets and stores bytes. A shadow copy kept by the bench predicts each returned byte, including repeated FIFO reads on both channels of guest 1.

// File: rtl/pbus_pkg.sv
// Package: shared field positions and types for the indirect peripheral bus bridge.
// Assumes two guests selected by one bit and an 8-bit guest bus.
package pbus_pkg;

    localparam int BIT_BUSY  = 25;
    localparam int BIT_DIR   = 23;
    localparam int BIT_GSEL  = 20;
    localparam int BIT_PHASE = 16;
    localparam int BYTE_W    = 8;
    localparam int GUESTS    = 2;

    // Latched command fields
    typedef struct packed {
        logic              dir;    // 1 = write to guest
        logic              gsel;   // guest index
        logic              phase;  // 0 = address, 1 = data
        logic [BYTE_W-1:0] byte_f; // address / data byte
    } cmd_t;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SETUP  = 2'd1,
        SQ_STROBE = 2'd2,
        SQ_HOLD   = 2'd3
    } sq_state_e;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_kind_e;

    // Classify a command into the guest cycle it produces
    function automatic op_kind_e op_of(input cmd_t c);
        if (!c.phase)   return OP_ADDR;
        else if (c.dir) return OP_WRITE;
        else            return OP_READ;
    endfunction

endpackage

// File: rtl/pbus_host_dec.sv
// Host decode: flags single-cycle host reads and writes that hit the command word.
// Assumes the host presents sel/wr/addr for exactly one cycle per access.
module pbus_host_dec #(
    parameter int              HOST_AW = 12,
    parameter logic [HOST_AW-1:0] CMD_OFS = 12'h200
) (
    input  logic               host_sel,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    output logic               wr_hit,
    output logic               rd_hit
);

    logic addr_match;

    // Compare the offset against the command word location
    always_comb begin
        addr_match = (host_addr == CMD_OFS);
        wr_hit     = host_sel &&  host_wr && addr_match;
        rd_hit     = host_sel && !host_wr && addr_match;
    end

endmodule

// File: rtl/pbus_cmd_reg.sv
// Command/status word: accepts commands while idle, holds busy, stores returned bytes.
// Assumes done and cap_en come from the sequencer, and start is consumed the same cycle.
module pbus_cmd_reg
    import pbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic [31:0]       wdata,
    input  logic              cap_en,
    input  logic [BYTE_W-1:0] cap_byte,
    input  logic              done,
    output logic              start,
    output logic              busy,
    output cmd_t              cmd,
    output logic [31:0]       rdata
);

    cmd_t cmd_q;
    logic busy_q;
    logic unused_wbits;

    assign unused_wbits = ^{wdata[31:24], wdata[22:21], wdata[19:17], wdata[15:8]};

    // A command is taken only while no guest cycle is outstanding
    always_comb start = wr_hit && !busy_q;

    // Busy flag: set on acceptance, cleared by the sequencer's done
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_q <= 1'b0;
        else if (start)  busy_q <= 1'b1;
        else if (done)   busy_q <= 1'b0;
    end

    // Command fields: loaded on acceptance, byte replaced by read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (start) begin
            cmd_q.dir    <= wdata[BIT_DIR];
            cmd_q.gsel   <= wdata[BIT_GSEL];
            cmd_q.phase  <= wdata[BIT_PHASE];
            cmd_q.byte_f <= wdata[BYTE_W-1:0];
        end else if (cap_en) begin
            cmd_q.byte_f <= cap_byte;
        end
    end

    // Assemble the host-visible word; unused bits read zero
    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            rdata[BIT_BUSY]     = busy_q;
            rdata[BIT_DIR]      = cmd_q.dir;
            rdata[BIT_GSEL]     = cmd_q.gsel;
            rdata[BIT_PHASE]    = cmd_q.phase;
            rdata[BYTE_W-1:0]   = cmd_q.byte_f;
        end
    end

    assign busy = busy_q;
    assign cmd  = cmd_q;

    // R3: busy is visible on the clock after acceptance
    p_busy_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy_q);

    // R4: a write while busy leaves the fields untouched
    p_ignore_busy_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && wr_hit && !cap_en) |=> $stable(cmd_q));

    // R9: busy only falls after the sequencer signals completion
    p_busy_fall_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(done));

endmodule

// File: rtl/pbus_seq.sv
// Guest bus sequencer: setup, strobe for STROBE_CLKS clocks, one hold clock.
// Assumes cmd is stable from start until done; STROBE_CLKS >= 1.
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int STROBE_CLKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cmd_t              cmd,
    input  logic [BYTE_W-1:0] gbus_ad_i,
    output logic [GUESTS-1:0] gbus_cs_n,
    output logic              gbus_ale,
    output logic              gbus_rd_n,
    output logic              gbus_wr_n,
    output logic [BYTE_W-1:0] gbus_ad_o,
    output logic              gbus_ad_oe,
    output logic              cap_en,
    output logic [BYTE_W-1:0] cap_byte,
    output logic              done
);

    localparam int CNT_W = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CLKS - 1);

    sq_state_e  state_q;
    logic [CNT_W-1:0] cnt_q;
    op_kind_e   op;
    logic       strobe_on;
    logic       last_strobe;

    always_comb begin
        op          = op_of(cmd);
        strobe_on   = (state_q == SQ_STROBE);
        last_strobe = strobe_on && (cnt_q == CNT_LAST);
    end

    // State progression of one guest cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            unique case (state_q)
                SQ_IDLE:   if (start)       state_q <= SQ_SETUP;
                SQ_SETUP:                   state_q <= SQ_STROBE;
                SQ_STROBE: if (last_strobe) state_q <= SQ_HOLD;
                SQ_HOLD:                    state_q <= SQ_IDLE;
                default:                    state_q <= SQ_IDLE;
            endcase
        end
    end

    // Strobe width counter
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (strobe_on)  cnt_q <= last_strobe ? '0 : cnt_q + 1'b1;
        else                 cnt_q <= '0;
    end

    // Chip select decode: one low line per active cycle
    generate
        for (genvar g = 0; g < GUESTS; g++) begin : g_cs
            assign gbus_cs_n[g] = !((state_q != SQ_IDLE) && (cmd.gsel == 1'(g)));
        end
    endgenerate

    // Strobes and bus drive derived from state and cycle kind
    always_comb begin
        gbus_ale   = strobe_on && (op == OP_ADDR);
        gbus_wr_n  = !(strobe_on && (op == OP_WRITE));
        gbus_rd_n  = !(strobe_on && (op == OP_READ));
        gbus_ad_oe = (state_q != SQ_IDLE) && (op != OP_READ);
        gbus_ad_o  = gbus_ad_oe ? cmd.byte_f : '0;
        cap_en     = last_strobe && (op == OP_READ);
        cap_byte   = gbus_ad_i;
        done       = (state_q == SQ_HOLD);
    end

    // R8: never more than one guest selected
    p_one_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~gbus_cs_n));

    // R5: strobes are mutually exclusive
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({gbus_ale, ~gbus_rd_n, ~gbus_wr_n}) <= 1);

    // R8: a strobe implies a selected guest
    p_strobe_has_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gbus_ale || !gbus_rd_n || !gbus_wr_n) |-> (gbus_cs_n != '1));

    // R7: bus released while the guest drives read data
    p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !gbus_rd_n |-> !gbus_ad_oe);

    // R5: strobe counter stays within the configured width
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < STROBE_CLKS);

endmodule

// File: rtl/pbus_bridge.sv
// Top: indirect peripheral bus bridge joining host decode, command word and sequencer.
// Assumes a single-cycle host register interface and two guests on one 8-bit bus.
module pbus_bridge
    import pbus_pkg::*;
#(
    parameter int                 HOST_AW     = 12,
    parameter logic [HOST_AW-1:0] CMD_OFS     = 12'h200,
    parameter int                 STROBE_CLKS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_sel,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic [1:0]         gbus_cs_n,
    output logic               gbus_ale,
    output logic               gbus_rd_n,
    output logic               gbus_wr_n,
    output logic [7:0]         gbus_ad_o,
    output logic               gbus_ad_oe,
    input  logic [7:0]         gbus_ad_i
);

    logic              wr_hit, rd_hit, start, busy, cap_en, done;
    logic [BYTE_W-1:0] cap_byte;
    cmd_t              cmd;

    pbus_host_dec #(.HOST_AW(HOST_AW), .CMD_OFS(CMD_OFS)) u_dec (
        .host_sel (host_sel),
        .host_wr  (host_wr),
        .host_addr(host_addr),
        .wr_hit   (wr_hit),
        .rd_hit   (rd_hit)
    );

    pbus_cmd_reg u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .rd_hit  (rd_hit),
        .wdata   (host_wdata),
        .cap_en  (cap_en),
        .cap_byte(cap_byte),
        .done    (done),
        .start   (start),
        .busy    (busy),
        .cmd     (cmd),
        .rdata   (host_rdata)
    );

    pbus_seq #(.STROBE_CLKS(STROBE_CLKS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd       (cmd),
        .gbus_ad_i (gbus_ad_i),
        .gbus_cs_n (gbus_cs_n),
        .gbus_ale  (gbus_ale),
        .gbus_rd_n (gbus_rd_n),
        .gbus_wr_n (gbus_wr_n),
        .gbus_ad_o (gbus_ad_o),
        .gbus_ad_oe(gbus_ad_oe),
        .cap_en    (cap_en),
        .cap_byte  (cap_byte),
        .done      (done)
    );

    // R9: a guest is selected only while the command word reports busy
    p_cs_needs_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gbus_cs_n != '1) |-> busy);

endmodule

// File: tb/sim_pbus_bridge.sv
// Directed bench for pbus_bridge with a behavioural two-guest model.
module sim_pbus_bridge;

    localparam int S = 2;
    localparam logic [11:0] CMD = 12'h200;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_sel, host_wr;
    logic [11:0] host_addr;
    logic [31:0] host_wdata, host_rdata;
    logic [1:0]  gbus_cs_n;
    logic        gbus_ale, gbus_rd_n, gbus_wr_n, gbus_ad_oe;
    logic [7:0]  gbus_ad_o, gbus_ad_i;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] gmem [2][256];   // guest model storage
    logic [7:0] glat [2];        // guest model latched offsets
    logic [7:0] shadow [2][256]; // bench prediction
    logic [7:0] exp_lat [2];

    always #2.5 clk = ~clk;

    pbus_bridge #(.STROBE_CLKS(S)) u0 (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .gbus_cs_n(gbus_cs_n), .gbus_ale(gbus_ale), .gbus_rd_n(gbus_rd_n),
        .gbus_wr_n(gbus_wr_n), .gbus_ad_o(gbus_ad_o), .gbus_ad_oe(gbus_ad_oe),
        .gbus_ad_i(gbus_ad_i)
    );

    // Guest model: latch offsets on ALE, store bytes on write strobe
    always @(posedge clk) begin
        for (int g = 0; g < 2; g++) begin
            if (!gbus_cs_n[g] && gbus_ale)   glat[g] <= gbus_ad_o;
            if (!gbus_cs_n[g] && !gbus_wr_n) gmem[g][glat[g]] <= gbus_ad_o;
        end
    end

    assign gbus_ad_i = (!gbus_rd_n && !gbus_cs_n[0]) ? gmem[0][glat[0]] :
                       (!gbus_rd_n && !gbus_cs_n[1]) ? gmem[1][glat[1]] : 8'h00;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Host read of an offset, sampled at a falling edge
    task automatic host_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
        #1 d = host_rdata;
    endtask

    // Issue one command and check every cycle of the guest transfer
    task automatic do_cmd(input logic [31:0] w, input string tag);
        logic [31:0] rd;
        logic        g;
        logic [1:0]  exp_cs;
        logic [7:0]  exp_b;
        g      = w[20];
        exp_cs = g ? 2'b01 : 2'b10;
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = CMD; host_wdata = w;
        @(negedge clk);
        host_wr = 1'b0; host_addr = CMD;
        #1;
        // Setup clock: busy, selected, no strobe
        chk(host_rdata[25] == 1'b1, {"R3 busy after accept ", tag}, host_rdata, 32'h0200_0000);
        chk(gbus_cs_n == exp_cs, {"R8 cs in setup ", tag}, gbus_cs_n, exp_cs);
        chk(gbus_ale == 1'b0 && gbus_rd_n && gbus_wr_n, {"R5 no strobe in setup ", tag},
            {gbus_ale, gbus_rd_n, gbus_wr_n}, 3'b011);
        for (int i = 0; i < S; i++) begin
            @(negedge clk); #1;
            chk(gbus_cs_n == exp_cs, {"R8 cs in strobe ", tag}, gbus_cs_n, exp_cs);
            chk(host_rdata[25] == 1'b1, {"R3 busy in strobe ", tag}, host_rdata[25], 1);
            if (!w[16]) begin
                chk(gbus_ale && gbus_rd_n && gbus_wr_n && gbus_ad_oe && gbus_ad_o == w[7:0],
                    {"R5 address strobe ", tag}, {gbus_ale, gbus_rd_n, gbus_wr_n, gbus_ad_oe, gbus_ad_o},
                    {4'b1111, w[7:0]});
            end else if (w[23]) begin
                chk(!gbus_ale && gbus_rd_n && !gbus_wr_n && gbus_ad_oe && gbus_ad_o == w[7:0],
                    {"R6 write strobe ", tag}, {gbus_ale, gbus_rd_n, gbus_wr_n, gbus_ad_oe, gbus_ad_o},
                    {4'b0101, w[7:0]});
            end else begin
                chk(!gbus_ale && !gbus_rd_n && gbus_wr_n && !gbus_ad_oe,
                    {"R7 read strobe ", tag}, {gbus_ale, gbus_rd_n, gbus_wr_n, gbus_ad_oe}, 4'b0010);
            end
        end
        @(negedge clk); #1;
        chk(gbus_cs_n == exp_cs && !gbus_ale && gbus_rd_n && gbus_wr_n,
            {"R9 hold clock ", tag}, {gbus_cs_n, gbus_ale, gbus_rd_n, gbus_wr_n}, {exp_cs, 3'b011});
        chk(host_rdata[25] == 1'b1, {"R9 busy in hold ", tag}, host_rdata[25], 1);
        @(negedge clk); #1;
        chk(host_rdata[25] == 1'b0 && gbus_cs_n == 2'b11, {"R9 release ", tag},
            {host_rdata[25], gbus_cs_n}, 3'b011);
        // Update the bench prediction and check the word contents
        exp_b = w[7:0];
        if (!w[16]) exp_lat[g] = w[7:0];
        else if (w[23]) shadow[g][exp_lat[g]] = w[7:0];
        else exp_b = shadow[g][exp_lat[g]];
        rd = host_rdata;
        chk(rd == ((w & 32'h0091_0000) | {24'h0, exp_b}), {"R1 R7 word after ", tag},
            rd, (w & 32'h0091_0000) | {24'h0, exp_b});
        host_sel = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk(gbus_cs_n == 2'b11 && !gbus_ale && gbus_rd_n && gbus_wr_n && !gbus_ad_oe,
            "R2 bus idle after reset", {gbus_cs_n, gbus_ale, gbus_rd_n, gbus_wr_n, gbus_ad_oe},
            6'b110110);
        host_read(CMD, d);
        chk(d == 32'h0, "R2 word after reset", d, 32'h0);
        host_sel = 1'b0;
    endtask

    task automatic t_offsets;
        logic [31:0] d;
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = 12'h204; host_wdata = 32'h0091_00AB;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
        #1 chk(gbus_cs_n == 2'b11, "R1 other offset starts no cycle", gbus_cs_n, 2'b11);
        host_read(12'h204, d);
        chk(d == 32'h0, "R1 other offset reads zero", d, 32'h0);
        host_read(CMD, d);
        chk(d == 32'h0, "R1 other offset write ignored", d, 32'h0);
        host_sel = 1'b0;
    endtask

    task automatic t_busy_write;
        logic [31:0] d;
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = CMD; host_wdata = 32'h0080_0033;
        @(negedge clk);
        host_wdata = 32'h0091_00CC; // second write lands while busy
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
        repeat (S + 4) @(negedge clk);
        #1 chk(gbus_cs_n == 2'b11, "R4 no second cycle", gbus_cs_n, 2'b11);
        exp_lat[0] = 8'h33;
        host_read(CMD, d);
        chk(d == 32'h0080_0033, "R4 busy write ignored", d, 32'h0080_0033);
        host_sel = 1'b0;
    endtask

    task automatic t_fifo;
        for (int k = 0; k < 3; k++) begin
            do_cmd(32'h0090_005F, "R10 fifo ch1 addr");
            do_cmd(32'h0011_0000, "R10 fifo ch1 read");
        end
        do_cmd(32'h0090_001F, "R10 fifo ch0 addr");
        do_cmd(32'h0011_0000, "R10 fifo ch0 read");
        do_cmd(32'h0080_001E, "R10 guest0 fifo addr");
        do_cmd(32'h0001_0000, "R10 guest0 fifo read");
    endtask

    initial begin
        for (int g = 0; g < 2; g++)
            for (int a = 0; a < 256; a++) begin
                gmem[g][a]   = 8'(a) ^ (g != 0 ? 8'hC3 : 8'h69);
                shadow[g][a] = 8'(a) ^ (g != 0 ? 8'hC3 : 8'h69);
            end
        glat[0] = 8'h00; glat[1] = 8'h00;
        exp_lat[0] = 8'h00; exp_lat[1] = 8'h00;
        rst_n = 1'b0; host_sel = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_offsets();
        do_cmd(32'h0080_001E, "R5 addr g0");
        do_cmd(32'h0081_005A, "R6 write g0");
        do_cmd(32'h0001_00FF, "R7 read g0");
        do_cmd(32'h0010_0040, "R5 addr dir0 g1");
        do_cmd(32'h0091_00E7, "R6 write g1");
        do_cmd(32'h0011_0000, "R7 read g1");
        t_busy_write();
        do_cmd(32'h0001_0000, "R7 read after busy test");
        t_fifo();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule